// File: doc/BRIEF.md
# SPI flash command sequencer

This block turns a single software "go" into one complete command on a serial flash bus. Software first loads a menu of eight opcodes, a two-bit kind for each menu slot, two prefix opcodes, a 24-bit flash address and, for writes, up to 64 data bytes in a small buffer. A write to the control word then picks a menu slot by index and starts the engine. The engine drives chip select low and sends the opcode. If the slot's kind calls for an address, it sends three address bytes. It then shifts data bytes out of the buffer or samples them into it, and raises a done flag.

A slot's kind says whether an address phase is sent and which way data flows. In atomic mode, one of the two prefix opcodes goes out first in its own chip-select frame. The bus is released for two SCK periods, and the indexed command follows without the engine going idle. One control bit chooses between a slow and a fast SCK rate, each given as a half period in system clocks.

Top module: `spi_flash_seq`

## Requirements
- R1: The bus registers read back what was written, at these word addresses. Word 2 holds the prefix opcodes: prefix 0 in bits 7:0, prefix 1 in bits 15:8. Word 3 holds the kinds: slot n in bits 2n+1:2n. Word 4 holds menu slots 0-3 and word 5 holds slots 4-7, one byte each, with the lowest slot in bits 7:0.
- R2: A command frame holds chip select low and sends the selected menu opcode MSB first in SPI mode 0. MOSI changes only while SCK is low, and SCK toggles only while chip select is low.
- R3: Word 0 keeps only address bits 23:0 and reads 0 in bits 31:24. Slots of kind 2 (read with address) and kind 3 (write with address) send those 24 bits MSB first, right after the opcode.
- R4: Kind 1 and kind 3 cycles with data shift out (count field + 1) bytes. The bytes are taken from the buffer in order. Buffer byte k sits in word 16 + k/4 at bits 8(k mod 4)+7:8(k mod 4).
- R5: Kind 0 and kind 2 cycles fill the buffer from byte 0, with the same little-endian packing. Each byte is sampled on the SCK rising edges.
- R6: With data-present (control bit 22) clear, no data phase runs: the frame is 8 bits, or 32 bits for address kinds, whatever the count field (bits 21:16) holds.
- R7: With atomic-select (bit 10) set, the prefix chosen by bit 11 is sent alone in an 8-bit frame. Chip select then stays high for exactly four SCK half periods, and the main frame follows.
- R8: Status word 1 has busy in bit 0, done in bit 2 and error in bit 3. Busy is high from go (bit 9) until the last SCK edge. Done rises on the cycle after busy falls. Writing 1 to bit 2 or bit 3 clears done or error.
- R9: A go written while busy starts nothing and sets error, even if that same write also asks for error to be cleared.
- R10: Clock-select bit 24 chooses the SCK half period: HALF_SLOW system clocks when clear, HALF_FAST when set. The menu index is bits 14:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address; upper half selects the data buffer |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A wrong phase state or byte counter shows up in the length of the recorded frame, or in a displaced byte, during the very command that triggers it. A bad bit counter or phase bit corrupts the opcode byte within the first eight SCK periods. A capture slip in a read leaves a rotated byte in the buffer, which is visible at the first readback after done. Faults in the divider or the gap counter show directly as measured SCK half periods or a chip-select gap of the wrong length.

// File: rtl/spi_flash_seq.sv
module spi_flash_seq #(
  parameter int HALF_SLOW = 3,
  parameter int HALF_FAST = 2,
  parameter int BUF_BYTES = 64,
  parameter int GAP_TICKS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic [$clog2(BUF_BYTES)-2:0]    reg_addr,
  input  logic [31:0]                     reg_wdata,
  output logic [31:0]                     reg_rdata,
  output logic                            spi_sck,
  output logic                            spi_cs_n,
  output logic                            spi_mosi,
  input  logic                            spi_miso
);
  localparam int BW   = $clog2(BUF_BYTES);
  localparam int AW   = BW - 1;
  localparam int DIVW = $clog2(HALF_SLOW + HALF_FAST + 1);
  localparam int GW   = $clog2(GAP_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_PFX, S_GAP, S_OP, S_ADR, S_DAT, S_FIN} st_t;

  st_t             st;
  logic [23:0]     faddr;
  logic [15:0]     pfx, otype;
  logic [63:0]     menu;
  logic [7:0]      buf_q [BUF_BYTES];
  logic            done_q, err_q, psel_q, csel_q, dp_q;
  logic [2:0]      idx_q, bitn;
  logic [BW-1:0]   cnt_q, bc;
  logic [DIVW-1:0] dcnt, half_m1;
  logic [GW-1:0]   gcnt;
  logic [7:0]      rx, txb;
  logic            sck_q, cs_q;

  wire [1:0] typ    = otype[{idx_q, 1'b0} +: 2];
  wire [7:0] opc    = menu[{idx_q, 3'b000} +: 8];
  wire       busy   = (st != S_IDLE) && (st != S_FIN);
  wire       go_wr  = reg_wr && (reg_addr == AW'(1)) && reg_wdata[9];
  wire       tick   = (dcnt == half_m1);
  wire       unused_bits = ^{reg_wdata[31:25], reg_wdata[23], reg_wdata[15], reg_wdata[7:4], reg_wdata[1:0]};

  assign half_m1  = csel_q ? DIVW'(HALF_FAST - 1) : DIVW'(HALF_SLOW - 1);
  assign spi_sck  = sck_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = txb[~bitn];

  always_comb begin
    case (st)
      S_PFX:   txb = psel_q ? pfx[15:8] : pfx[7:0];
      S_OP:    txb = opc;
      S_ADR:   txb = (bc[1:0] == 2'd0) ? faddr[23:16] : (bc[1:0] == 2'd1) ? faddr[15:8] : faddr[7:0];
      S_DAT:   txb = typ[0] ? buf_q[bc] : 8'h00;
      default: txb = 8'h00;
    endcase
  end

  always_comb begin
    reg_rdata = 32'h0;
    if (reg_addr[AW-1])
      reg_rdata = {buf_q[{reg_addr[AW-2:0], 2'd3}], buf_q[{reg_addr[AW-2:0], 2'd2}],
                   buf_q[{reg_addr[AW-2:0], 2'd1}], buf_q[{reg_addr[AW-2:0], 2'd0}]};
    else
      case (reg_addr)
        AW'(0): reg_rdata = {8'h0, faddr};
        AW'(1): reg_rdata = {28'h0, err_q, done_q, 1'b0, busy};
        AW'(2): reg_rdata = {16'h0, pfx};
        AW'(3): reg_rdata = {16'h0, otype};
        AW'(4): reg_rdata = menu[31:0];
        AW'(5): reg_rdata = menu[63:32];
        default: reg_rdata = 32'h0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; faddr <= '0; pfx <= '0; otype <= '0; menu <= '0;
      done_q <= 1'b0; err_q <= 1'b0; psel_q <= 1'b0; csel_q <= 1'b0; dp_q <= 1'b0;
      idx_q <= '0; bitn <= '0; cnt_q <= '0; bc <= '0; dcnt <= '0; gcnt <= '0;
      rx <= '0; sck_q <= 1'b0; cs_q <= 1'b1;
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= 8'h00;
    end else begin
      if (st == S_FIN) begin
        done_q <= 1'b1;
        st     <= S_IDLE;
      end
      if (reg_wr) begin
        if (reg_addr[AW-1]) begin
          for (int b = 0; b < 4; b++) buf_q[{reg_addr[AW-2:0], 2'(b)}] <= reg_wdata[8*b +: 8];
        end else
          case (reg_addr)
            AW'(0): faddr <= reg_wdata[23:0];
            AW'(1): begin
              if (reg_wdata[2]) done_q <= 1'b0;
              if (reg_wdata[3]) err_q  <= 1'b0;
            end
            AW'(2): pfx   <= reg_wdata[15:0];
            AW'(3): otype <= reg_wdata[15:0];
            AW'(4): menu[31:0]  <= reg_wdata;
            AW'(5): menu[63:32] <= reg_wdata;
            default: ;
          endcase
      end
      if (go_wr && busy) err_q <= 1'b1;
      else if (go_wr) begin
        idx_q  <= reg_wdata[14:12];
        psel_q <= reg_wdata[11];
        cnt_q  <= reg_wdata[16 +: BW];
        dp_q   <= reg_wdata[22];
        csel_q <= reg_wdata[24];
        st     <= reg_wdata[10] ? S_PFX : S_OP;
        cs_q   <= 1'b0; sck_q <= 1'b0; bitn <= '0; bc <= '0; dcnt <= '0; gcnt <= '0;
      end
      if (busy) begin
        dcnt <= tick ? '0 : dcnt + DIVW'(1);
        if (tick) begin
          if (st == S_GAP) begin
            gcnt <= gcnt + GW'(1);
            if (gcnt == GW'(GAP_TICKS - 1)) begin
              st <= S_OP; cs_q <= 1'b0; gcnt <= '0;
            end
          end else if (!sck_q) begin
            sck_q <= 1'b1;
            rx    <= {rx[6:0], spi_miso};
          end else begin
            sck_q <= 1'b0;
            bitn  <= bitn + 3'd1;
            if (bitn == 3'd7)
              case (st)
                S_PFX: begin st <= S_GAP; cs_q <= 1'b1; end
                S_OP: begin
                  bc <= '0;
                  if (typ[1]) st <= S_ADR;
                  else if (dp_q) st <= S_DAT;
                  else begin st <= S_FIN; cs_q <= 1'b1; end
                end
                S_ADR: begin
                  if (bc == BW'(2)) begin
                    bc <= '0;
                    if (dp_q) st <= S_DAT;
                    else begin st <= S_FIN; cs_q <= 1'b1; end
                  end else bc <= bc + BW'(1);
                end
                S_DAT: begin
                  if (!typ[0]) buf_q[bc] <= rx;
                  if (bc == cnt_q) begin st <= S_FIN; cs_q <= 1'b1; end
                  else bc <= bc + BW'(1);
                end
                default: ;
              endcase
          end
        end
      end
    end
  end

  a_r2_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n) spi_sck |-> !spi_cs_n);
  a_r2_mosi_hold:    assert property (@(posedge clk) disable iff (!rst_n) (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  a_r8_cs_busy:      assert property (@(posedge clk) disable iff (!rst_n) !spi_cs_n |-> busy);
  a_r8_done_follow:  assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |=> done_q);
  a_r9_go_busy_err:  assert property (@(posedge clk) disable iff (!rst_n) (go_wr && busy) |=> (err_q && busy));
endmodule

// File: tb/spi_flash_seq_tb.sv
module spi_flash_seq_tb;
  localparam int HS = 3, HF = 2;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic miso_r = 0;

  spi_flash_seq #(.HALF_SLOW(HS), .HALF_FAST(HF)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(miso_r));

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  int nfr = 0, curbits = 0;
  int fb [2];
  logic [7:0] frb [2][80];
  int t_fall [2];
  int t_rise [2];
  int t_sr = 0, t_sf = 0, hi_len = 0, lo_len = 0;
  bit seq_ok;

  always @(posedge clk) cyc++;

  function automatic logic [7:0] mop(int i);   return 8'(8'h10 + i * 29); endfunction
  function automatic logic [7:0] spat(int j);  return 8'(j * 37 + 11);   endfunction
  function automatic logic [7:0] bpat(int k);  return 8'(k * 5 + 3);     endfunction
  function automatic logic [31:0] ctl(int idx, int dp, int n, int atom, int ps, int cs);
    return (32'(cs) << 24) | (32'(dp) << 22) | (32'((n - 1) & 63) << 16) | (32'(idx) << 12)
         | (32'(ps) << 11) | (32'(atom) << 10) | 32'h20C;
  endfunction

  always @(negedge spi_cs_n) begin
    if (nfr < 2) begin fb[nfr] = 0; t_fall[nfr] = cyc; end
    nfr++;
    curbits = 0;
    miso_r = spat(0)[7];
  end
  always @(posedge spi_cs_n) if (nfr >= 1 && nfr <= 2) t_rise[nfr-1] = cyc;
  always @(posedge spi_sck) begin
    if (nfr >= 1 && nfr <= 2) begin
      frb[nfr-1][fb[nfr-1]/8] = {frb[nfr-1][fb[nfr-1]/8][6:0], spi_mosi};
      fb[nfr-1]++;
    end
    curbits++;
    miso_r = spat(curbits / 8)[7 - curbits % 8];
    t_sr = cyc; lo_len = t_sr - t_sf;
  end
  always @(negedge spi_sck) begin t_sf = cyc; hi_len = t_sf - t_sr; end

  task automatic chk(string tag, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    int ks = -1;
    seq_ok = 0;
    for (int k = 0; k < 20000; k++) begin
      rd(5'd1, s);
      if (!s[0] && ks < 0) begin ks = k; if (s[2]) break; end
      else if (s[2]) begin seq_ok = (k == ks + 1); break; end
    end
  endtask

  task automatic run(input logic [31:0] c);
    nfr = 0;
    wr(5'd1, c);
    wait_done();
  endtask

  initial begin
    #3_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hdr;
    repeat (3) @(negedge clk);
    chk("R8 reset status", reg_rdata, 0);
    chk("R2 reset cs_n", spi_cs_n, 1);
    chk("R2 reset sck", spi_sck, 0);
    rst_n = 1;

    wr(5'd2, 32'h0000_5006);
    wr(5'd3, 32'h0000_E4E4);
    wr(5'd4, {mop(3), mop(2), mop(1), mop(0)});
    wr(5'd5, {mop(7), mop(6), mop(5), mop(4)});
    wr(5'd0, 32'hFF12_3456);
    rd(5'd2, d); chk("R1 prefix readback", d, 32'h5006);
    rd(5'd3, d); chk("R1 kind readback", d, 32'hE4E4);
    rd(5'd4, d); chk("R1 menu low", d, {mop(3), mop(2), mop(1), mop(0)});
    rd(5'd5, d); chk("R1 menu high", d, {mop(7), mop(6), mop(5), mop(4)});
    rd(5'd0, d); chk("R3 address keeps 24 bits", d, 32'h0012_3456);
    for (int w = 0; w < 16; w++) wr(5'(16 + w), {bpat(4*w+3), bpat(4*w+2), bpat(4*w+1), bpat(4*w)});

    // R2 R3 R6: every menu slot without data, both clock rates
    for (int cs = 0; cs < 2; cs++)
      for (int i = 0; i < 8; i++) begin
        run(ctl(i, 0, (i == 3) ? 6 : 1, 0, 0, cs));
        chk("R6 frame count", nfr, 1);
        chk("R6 frame bits", fb[0], (i % 4 >= 2) ? 32 : 8);
        chk("R2 opcode byte", frb[0][0], mop(i));
        if (i % 4 >= 2) begin
          chk("R3 addr hi", frb[0][1], 8'h12);
          chk("R3 addr mid", frb[0][2], 8'h34);
          chk("R3 addr lo", frb[0][3], 8'h56);
        end
        chk("R8 done one cycle after busy", seq_ok, 1);
        chk("R10 sck high length", hi_len, cs ? HF : HS);
        chk("R10 sck low length", lo_len, cs ? HF : HS);
      end

    // R4: write with address and write without address
    foreach (fb[j]) fb[j] = 0;
    for (int t = 0; t < 5; t++) begin
      int n, idx;
      n   = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 7 : (t == 3) ? 64 : 9;
      idx = (t == 4) ? 5 : 3;
      hdr = (t == 4) ? 1 : 4;
      run(ctl(idx, 1, n, 0, 0, t & 1));
      chk("R4 write frame bits", fb[0], 8 * (hdr + n));
      for (int k = 0; k < n; k++) chk("R4 write data byte", frb[0][hdr + k], bpat(k));
    end

    // R5: reads with and without address
    for (int t = 0; t < 3; t++) begin
      int n, idx;
      n   = (t == 0) ? 5 : (t == 1) ? 64 : 3;
      idx = (t == 2) ? 4 : 2;
      hdr = (t == 2) ? 1 : 4;
      run(ctl(idx, 1, n, 0, 0, 1));
      chk("R5 read frame bits", fb[0], 8 * (hdr + n));
      for (int k = 0; k < n; k++) begin
        if (k % 4 == 0) rd(5'(16 + k / 4), d);
        chk("R5 read buffer byte", d[8*(k%4) +: 8], spat(hdr + k));
      end
    end

    // R7: atomic prefix frame, both prefixes, both rates
    for (int p = 0; p < 2; p++) begin
      run(ctl(1, 0, 1, 1, p, p));
      chk("R7 frame count", nfr, 2);
      chk("R7 prefix bits", fb[0], 8);
      chk("R7 prefix byte", frb[0][0], p ? 8'h50 : 8'h06);
      chk("R7 main opcode", frb[1][0], mop(1));
      chk("R7 gap cycles", t_fall[1] - t_rise[0], 4 * (p ? HF : HS));
    end

    // R9: go while busy
    nfr = 0;
    wr(5'd1, ctl(2, 1, 64, 0, 0, 0));
    repeat (50) @(negedge clk);
    wr(5'd1, ctl(3, 0, 1, 0, 0, 0));
    wait_done();
    rd(5'd1, d);
    chk("R9 error set", d[3], 1);
    chk("R9 no second frame", nfr, 1);
    chk("R9 first cycle intact", fb[0], 8 * 68);
    wr(5'd1, 32'h0000_000C);
    rd(5'd1, d);
    chk("R8 write-one clears", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule